// File: doc/BRIEF.md
# Receive Polarity Detect and Correct Controller

This block decides whether the receive pair of a twisted-pair port is wired backwards. It reads the decoded end-of-transmission delimiter of each incoming packet and inverts the receive data path when needed. Each packet end arrives as a one-cycle strobe. With it come a flag that says whether the delimiter was well formed and a flag that says which polarity it showed.

After a reset or a link failure the controller is armed. The first good delimiter sets the polarity outright. A later good delimiter that disagrees replaces it. A later good delimiter that agrees freezes the decision until the next link failure or reset. A correction-disable input stops the data path from ever being inverted, but detection keeps running and the status outputs still report the detected polarity.

Top module: `rx_polarity_ctrl`

## Requirements
- R1: While `srst` is high at a clock edge, the controller clears to normal polarity and becomes armed with no held decision. After that edge `rxInvert`=0, `revPolStatus`=0 and `polOkN`=0.
- R2: When armed with no held decision, a strobe with `etdValid`=1 adopts `etdReversed` (1 = reversed, 0 = normal) as the polarity. The outputs show it in the cycle after the strobe edge.
- R3: When armed with a held decision, a valid strobe whose polarity differs replaces the held polarity, and the controller stays armed.
- R4: When armed with a held decision, a valid strobe whose polarity matches locks the decision. While locked, valid strobes change nothing.
- R5: A strobe with `etdValid`=0 changes neither the polarity nor the agreement state. A valid strobe that matches the held polarity still locks after any number of invalid strobes in between.
- R6: Without `pktEnd`, the values on `etdValid` and `etdReversed` have no effect.
- R7: `linkFail` re-arms the controller and clears the held decision, but keeps the current polarity. A strobe in the same cycle as `linkFail` is ignored.
- R8: `revPolStatus` is 1 exactly when the decided polarity is reversed. `polOkN` is active low: 0 for normal polarity, 1 for reversed.
- R9: With `corrDisable`=1, `rxInvert` is 0 and detection still updates `revPolStatus` and `polOkN`. With `corrDisable`=0, `rxInvert` equals `revPolStatus`.
- R10: `srst` re-arms a locked controller and returns the polarity to normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| pktEnd | input | 1 | One-cycle strobe at each packet end |
| etdValid | input | 1 | Delimiter of this packet is well formed |
| etdReversed | input | 1 | Delimiter showed reversed polarity |
| linkFail | input | 1 | Link-fail condition, re-arms detection |
| corrDisable | input | 1 | Blocks inversion of the data path |
| rxInvert | output | 1 | Invert select for the receive data path |
| revPolStatus | output | 1 | Reversed polarity detected |
| polOkN | output | 1 | Polarity-OK indicator, active low |

## Verification
The bench covers these corner cases and what a faulty design would show on them:
- A disagree-then-agree pair must lock only on the agreeing packet. A design that locks on the second packet regardless of polarity would freeze the wrong polarity.
- Invalid delimiters placed between two agreeing valid ones must not reset the agreement. A design that counts them would never lock, or would adopt their polarity.
- A link failure in the same cycle as a packet strobe must re-arm without taking the packet. A later valid packet must then set the polarity again, so a design that stays locked is caught.
- With correction disabled, status must keep tracking while the data path stays uninverted.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;
  localparam int POL_W = 1;
  localparam logic [POL_W-1:0] POL_NORMAL = '0;

  typedef enum logic [1:0] {
    ST_WAIT      = 2'd0,
    ST_TENTATIVE = 2'd1,
    ST_LOCKED    = 2'd2
  } polState_t;

  typedef struct packed {
    logic loadPol;
    logic clearPol;
  } polStrobe_t;
endpackage

// File: rtl/rx_polarity_ctl.sv
module rx_polarity_ctl
  import rx_polarity_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       pktEnd,
  input  logic       etdValid,
  input  logic       etdReversed,
  input  logic       linkFail,
  input  logic       polCur,
  output polStrobe_t ctl
);
  polState_t state, stateNext;
  logic goodPkt;

  assign goodPkt = pktEnd && etdValid && !linkFail;

  always_comb begin
    stateNext    = state;
    ctl.loadPol  = 1'b0;
    ctl.clearPol = srst;
    if (linkFail) begin
      stateNext = ST_WAIT;
    end else if (goodPkt) begin
      case (state)
        ST_WAIT: begin
          ctl.loadPol = 1'b1;
          stateNext   = ST_TENTATIVE;
        end
        ST_TENTATIVE: begin
          if (etdReversed == polCur) stateNext = ST_LOCKED;
          else ctl.loadPol = 1'b1;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) state <= ST_WAIT;
    else      state <= stateNext;
  end

  // R4: a locked decision holds until link fail
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (srst)
    (state == ST_LOCKED && !linkFail) |=> (state == ST_LOCKED));

  // R4: no polarity load is issued while locked
  a_r4_no_load_locked: assert property (@(posedge clk) disable iff (srst)
    (state == ST_LOCKED) |-> !ctl.loadPol);

  // R7: link fail always re-arms
  a_r7_linkfail_rearm: assert property (@(posedge clk) disable iff (srst)
    linkFail |=> (state == ST_WAIT));

  // R2: first valid delimiter after arming sets the polarity
  a_r2_first_adopt: assert property (@(posedge clk) disable iff (srst)
    (state == ST_WAIT && goodPkt) |=> (polCur == $past(etdReversed)));
endmodule

// File: rtl/rx_polarity_dp.sv
module rx_polarity_dp
  import rx_polarity_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  polStrobe_t ctl,
  input  logic       etdReversed,
  input  logic       corrDisable,
  output logic       polCur,
  output logic       rxInvert,
  output logic       revPolStatus,
  output logic       polOkN
);
  logic polReg;

  always_ff @(posedge clk) begin
    if (ctl.clearPol)     polReg <= POL_NORMAL;
    else if (ctl.loadPol) polReg <= etdReversed;
  end

  assign polCur       = polReg;
  assign revPolStatus = polReg;
  assign polOkN       = polReg;
  assign rxInvert     = polReg && !corrDisable;

  // R5: polarity only moves on a strobe from control
  a_r5_hold_without_load: assert property (@(posedge clk) disable iff (srst)
    (!ctl.loadPol && !ctl.clearPol) |=> $stable(revPolStatus));
endmodule

// File: rtl/rx_polarity_ctrl.sv
module rx_polarity_ctrl
  import rx_polarity_pkg::*;
(
  input  logic clk,
  input  logic srst,
  input  logic pktEnd,
  input  logic etdValid,
  input  logic etdReversed,
  input  logic linkFail,
  input  logic corrDisable,
  output logic rxInvert,
  output logic revPolStatus,
  output logic polOkN
);
  polStrobe_t ctl;
  logic polCur;

  rx_polarity_ctl u_ctl (
    .clk(clk), .srst(srst), .pktEnd(pktEnd), .etdValid(etdValid),
    .etdReversed(etdReversed), .linkFail(linkFail), .polCur(polCur), .ctl(ctl)
  );

  rx_polarity_dp u_dp (
    .clk(clk), .srst(srst), .ctl(ctl), .etdReversed(etdReversed),
    .corrDisable(corrDisable), .polCur(polCur), .rxInvert(rxInvert),
    .revPolStatus(revPolStatus), .polOkN(polOkN)
  );
endmodule

// File: tb/rx_polarity_ctrl_test.sv
module rx_polarity_ctrl_test;
  logic clk = 1'b0;
  logic srst = 1'b1, pktEnd = 1'b0, etdValid = 1'b0, etdReversed = 1'b0;
  logic linkFail = 1'b0, corrDisable = 1'b0;
  logic rxInvert, revPolStatus, polOkN;
  int vectors = 0, fails = 0;
  bit done = 0;
  logic mPol = 1'b0, mHave = 1'b0, mLock = 1'b0;

  always #5 clk = ~clk;

  rx_polarity_ctrl uut (
    .clk(clk), .srst(srst), .pktEnd(pktEnd), .etdValid(etdValid),
    .etdReversed(etdReversed), .linkFail(linkFail), .corrDisable(corrDisable),
    .rxInvert(rxInvert), .revPolStatus(revPolStatus), .polOkN(polOkN)
  );

  function automatic logic expInvert(logic pol, logic dis);
    return pol && !dis;
  endfunction

  task automatic modelStep();
    if (srst) begin
      mPol = 1'b0; mHave = 1'b0; mLock = 1'b0;
    end else if (linkFail) begin
      mHave = 1'b0; mLock = 1'b0;
    end else if (pktEnd && etdValid && !mLock) begin
      if (!mHave) begin mPol = etdReversed; mHave = 1'b1; end
      else if (etdReversed == mPol) mLock = 1'b1;
      else mPol = etdReversed;
    end
  endtask

  task automatic check(string req);
    logic eI = expInvert(mPol, corrDisable);
    vectors++;
    if (rxInvert !== eI || revPolStatus !== mPol || polOkN !== mPol) begin
      fails++;
      $display("FAIL %s: got inv=%b rev=%b okN=%b, expected inv=%b rev=%b okN=%b",
               req, rxInvert, revPolStatus, polOkN, eI, mPol, mPol);
    end
  endtask

  task automatic cyc(logic rs, logic pk, logic vl, logic rv, logic lf, logic ds, string req);
    srst = rs; pktEnd = pk; etdValid = vl; etdReversed = rv; linkFail = lf; corrDisable = ds;
    @(posedge clk);
    modelStep();
    #1;
    check(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, "R1 reset state");
    cyc(0, 1, 1, 1, 0, 0, "R2 first packet adopts reversed");
    cyc(0, 1, 1, 0, 0, 0, "R3 disagree replaces");
    cyc(0, 1, 0, 1, 0, 0, "R5 invalid ignored");
    cyc(0, 1, 0, 1, 0, 0, "R5 second invalid ignored");
    cyc(0, 1, 1, 0, 0, 0, "R4 agreement locks normal");
    cyc(0, 1, 1, 1, 0, 0, "R4 locked ignores disagree");
    cyc(0, 1, 1, 1, 0, 0, "R4 locked ignores repeat");
    cyc(0, 0, 1, 1, 0, 0, "R6 flags without strobe ignored");
    cyc(0, 1, 1, 1, 1, 0, "R7 linkFail beats same-cycle strobe");
    cyc(0, 1, 1, 1, 0, 0, "R7 re-armed adopts new polarity");
    cyc(0, 1, 1, 1, 0, 0, "R8 locked reversed status");
    cyc(0, 0, 0, 0, 1, 0, "R7 linkFail keeps polarity");
    cyc(0, 1, 1, 0, 0, 1, "R9 disabled still detects");
    cyc(0, 1, 1, 1, 0, 1, "R9 disabled reversed no invert");
    cyc(0, 0, 0, 0, 0, 0, "R9 enabled inverts");
    cyc(0, 1, 1, 1, 0, 0, "R4 locked after disabled pair");
    cyc(1, 0, 0, 0, 0, 0, "R10 reset clears locked reversed");
    cyc(0, 1, 1, 0, 0, 0, "R10 re-armed after reset");
    cyc(0, 1, 1, 1, 0, 0, "R10 not locked after single packet");
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic rs = ($urandom % 100) < 2;
      logic lf = ($urandom % 100) < 4;
      logic pk = ($urandom % 100) < 40;
      logic vl = ($urandom % 100) < 70;
      logic rv = $urandom % 2;
      logic ds = ($urandom % 100) < 20;
      cyc(rs, pk, vl, rv, lf, ds, "R8/R9 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule